// File: doc/BRIEF.md
# Stream Process Wrapper Controller

This block turns a fixed-latency compute core into one self-timed dataflow process with two FIFO input ports and two FIFO output ports. After a start pulse it sweeps a static two-level iteration space (outer index `i`, inner index `j`, inner index fastest). For every iteration it runs the same sequence. First a control step evaluates guard conditions that are affine in `i`, `j` and the constant `N`. A read step then takes one token from the input chosen by the guards. An execute step sends the operand through the core. A write step copies the core result to every output port whose guard holds.

The block has no central scheduler. It moves forward only on its own FIFO handshakes. A read waits while the chosen input FIFO is empty, and a write waits while a chosen output FIFO is full. If no input guard holds, the read step is skipped and the core works on the operand kept from the last read. The stand-in core computes `2*x+1` (modulo 2^DW) and takes `LAT` cycles.

The state machine has six states:
- `S_IDLE` goes to `S_CTRL` on start.
- `S_CTRL` goes to `S_READ` when an input guard holds, and to `S_ISSUE` when none does.
- `S_READ` goes to `S_ISSUE` on the pop.
- `S_ISSUE` goes to `S_WAIT` after it hands the operand to the core.
- `S_WAIT` goes to `S_WRITE` when the core result is valid.
- `S_WRITE` goes to `S_CTRL` once all chosen outputs are written. After the final iteration it goes to `S_IDLE` instead and pulses done.

Top module: `spw_ctrl`

## Requirements
- R1: After a start pulse in idle, the iterations run in the order i = 0..I_CNT-1 (outer) and j = 0..J_CNT-1 (inner), each through control, read, execute and write.
- R2: The read guards are affine in i and N. Input port 0 is read when i < N. Input port 1 is read when i == N. No port is read when i > N, and the core then uses the operand held from the last read.
- R3: The output guards are evaluated independently. Output port 0 is written when i <= N-1, and output port 1 is written when j == J_CNT-1. One result may therefore go to both ports, to one port or to none.
- R4: `in_rd` is never asserted for a port whose `in_empty` is high, and at most one bit of `in_rd` is set. A read waits for data.
- R5: `out_wr` is never asserted for a port whose `out_full` is high. Each chosen port receives exactly one write per iteration, and the write waits for space.
- R6: The core result is 2*operand+1, truncated to DW bits. With no stalls, the first output write comes LAT+2 cycles after the pop that supplied its operand.
- R7: On each output port the tokens appear in iteration order, and on each input port the tokens are consumed in FIFO order.
- R8: `done` is high for exactly one cycle after the last iteration's writes finish, and the block then returns to idle.
- R9: After reset the block is idle. It asserts no `in_rd`, `out_wr` or `done`, even when inputs hold data.
- R10: A start pulse during a sweep has no effect. The token counts and the single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins one iteration sweep when idle |
| in_empty | input | 2 | Empty flag of each input FIFO |
| in_data | input | 2*DW | Head token of each input FIFO, port k at bits k*DW upward |
| in_rd | output | 2 | Pop strobe for each input FIFO |
| out_full | input | 2 | Full flag of each output FIFO |
| out_wr | output | 2 | Push strobe for each output FIFO |
| out_data | output | DW | Result token shared by both outputs |
| done | output | 1 | One-cycle pulse when a sweep ends |

## Verification
The assertions assume first-word-fall-through input FIFOs, where `in_data` is valid whenever `in_empty` is low. They also assume that the empty and full flags may change in any cycle, with no promise that they will ever release. The bench drives flags and data only at the falling clock edge. It holds each input's empty flag high once its supply is used up, and it draws random starvation and backpressure in each cycle. As a result the flags never change between the controller's combinational decision and the edge that commits it, and every stall eventually clears.

// File: rtl/spw_pkg.sv
package spw_pkg;
    localparam int NPORT = 2;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CTRL  = 3'd1,
        S_READ  = 3'd2,
        S_ISSUE = 3'd3,
        S_WAIT  = 3'd4,
        S_WRITE = 3'd5
    } spw_state_e;
endpackage

// File: rtl/spw_loop_nest.sv
module spw_loop_nest #(
    parameter int I_CNT = 4,
    parameter int J_CNT = 3,
    parameter int IW    = 2,
    parameter int JW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [IW-1:0] idx_i,
    output logic [JW-1:0] idx_j,
    output logic          is_last
);
    localparam logic [IW-1:0] I_LAST = IW'(I_CNT - 1);
    localparam logic [JW-1:0] J_LAST = JW'(J_CNT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_i <= '0;
            idx_j <= '0;
        end else if (step) begin
            if (idx_j == J_LAST) begin
                idx_j <= '0;
                idx_i <= (idx_i == I_LAST) ? '0 : idx_i + 1'b1;
            end else begin
                idx_j <= idx_j + 1'b1;
            end
        end
    end

    assign is_last = (idx_i == I_LAST) && (idx_j == J_LAST);
endmodule

// File: rtl/spw_guard.sv
module spw_guard #(
    parameter int N_PAR = 2,
    parameter int J_CNT = 3,
    parameter int IW    = 2,
    parameter int JW    = 2
) (
    input  logic [IW-1:0] idx_i,
    input  logic [JW-1:0] idx_j,
    output logic [1:0]    rd_sel,
    output logic [1:0]    wr_sel
);
    localparam logic [IW-1:0] N_V    = IW'(N_PAR);
    localparam logic [JW-1:0] J_LAST = JW'(J_CNT - 1);

    always_comb begin
        rd_sel[0] = (idx_i < N_V);
        rd_sel[1] = (idx_i == N_V);
        wr_sel[0] = (idx_i < N_V);
        wr_sel[1] = (idx_j == J_LAST);
    end
endmodule

// File: rtl/spw_core.sv
module spw_core #(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] operand,
    output logic          res_vld,
    output logic [DW-1:0] res_data
);
    logic [LAT-1:0] vld_q;
    logic [DW-1:0]  dat_q [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q[0] <= 1'b0;
        else        vld_q[0] <= go;
        dat_q[0] <= {operand[DW-2:0], 1'b0} + DW'(1);
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) vld_q[s] <= 1'b0;
            else        vld_q[s] <= vld_q[s-1];
            dat_q[s] <= dat_q[s-1];
        end
    end

    assign res_vld  = vld_q[LAT-1];
    assign res_data = dat_q[LAT-1];
endmodule

// File: rtl/spw_ctrl.sv
module spw_ctrl #(
    parameter int DW    = 32,
    parameter int I_CNT = 4,
    parameter int J_CNT = 3,
    parameter int N_PAR = 2,
    parameter int LAT   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [spw_pkg::NPORT-1:0]    in_empty,
    input  logic [spw_pkg::NPORT*DW-1:0] in_data,
    output logic [spw_pkg::NPORT-1:0]    in_rd,
    input  logic [spw_pkg::NPORT-1:0]    out_full,
    output logic [spw_pkg::NPORT-1:0]    out_wr,
    output logic [DW-1:0]                out_data,
    output logic                         done
);
    import spw_pkg::*;

    localparam int IW = (I_CNT > 2) ? $clog2(I_CNT) : 1;
    localparam int JW = (J_CNT > 2) ? $clog2(J_CNT) : 1;

    spw_state_e        state_q, state_d;
    logic [IW-1:0]     idx_i;
    logic [JW-1:0]     idx_j;
    logic              is_last, step, clear, core_go, core_vld, wr_clear;
    logic [1:0]        rd_g, wr_g, rd_sel_q, wr_pend_q;
    logic [DW-1:0]     op_q, res_q, core_res;
    logic              done_q;
    logic              idle_w;

    spw_loop_nest #(.I_CNT(I_CNT), .J_CNT(J_CNT), .IW(IW), .JW(JW)) u_loops (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .idx_i(idx_i), .idx_j(idx_j), .is_last(is_last)
    );

    spw_guard #(.N_PAR(N_PAR), .J_CNT(J_CNT), .IW(IW), .JW(JW)) u_guard (
        .idx_i(idx_i), .idx_j(idx_j), .rd_sel(rd_g), .wr_sel(wr_g)
    );

    spw_core #(.DW(DW), .LAT(LAT)) u_core (
        .clk(clk), .rst_n(rst_n), .go(core_go), .operand(op_q),
        .res_vld(core_vld), .res_data(core_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        in_rd    = '0;
        out_wr   = '0;
        core_go  = 1'b0;
        step     = 1'b0;
        clear    = 1'b0;
        wr_clear = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    clear   = 1'b1;
                    state_d = S_CTRL;
                end
            end
            S_CTRL:  state_d = (|rd_g) ? S_READ : S_ISSUE;
            S_READ: begin
                in_rd = rd_sel_q & ~in_empty;
                if (|in_rd) state_d = S_ISSUE;
            end
            S_ISSUE: begin
                core_go = 1'b1;
                state_d = S_WAIT;
            end
            S_WAIT:  if (core_vld) state_d = S_WRITE;
            S_WRITE: begin
                out_wr   = wr_pend_q & ~out_full;
                wr_clear = ((wr_pend_q & out_full) == 2'b00);
                if (wr_clear) begin
                    step    = 1'b1;
                    state_d = is_last ? S_IDLE : S_CTRL;
                end
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel_q  <= '0;
            wr_pend_q <= '0;
            op_q      <= '0;
            res_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (state_q == S_WRITE) && wr_clear && is_last;
            if (state_q == S_CTRL) begin
                rd_sel_q  <= rd_g;
                wr_pend_q <= wr_g;
            end
            if (in_rd[1])      op_q <= in_data[DW +: DW];
            else if (in_rd[0]) op_q <= in_data[0 +: DW];
            if (state_q == S_WAIT && core_vld) res_q <= core_res;
            if (state_q == S_WRITE) wr_pend_q <= wr_pend_q & out_full;
        end
    end

    assign idle_w   = (state_q == S_IDLE);
    assign out_data = res_q;
    assign done     = done_q;
endmodule

// File: rtl/spw_ctrl_chk.sv
module spw_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] in_empty,
    input logic [1:0] in_rd,
    input logic [1:0] out_full,
    input logic [1:0] out_wr,
    input logic       done,
    input logic       idle_w
);
    p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rd & in_empty) == 2'b00);
    p_single_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_rd));
    p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr & out_full) == 2'b00);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle_w);
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_w |-> (in_rd == 2'b00 && out_wr == 2'b00));
endmodule

bind spw_ctrl spw_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd(in_rd),
    .out_full(out_full), .out_wr(out_wr), .done(done), .idle_w(idle_w)
);

// File: tb/spw_ctrl_bench.sv
module spw_ctrl_bench;
    localparam int DW = 32, I_CNT = 4, J_CNT = 3, N_PAR = 2, LAT = 3;
    localparam int NV = 4;
    localparam logic [31:0] V_B0 [NV] = '{32'h0000_0010, 32'h7FFF_FFF0, 32'h0000_1234, 32'hA5A5_0000};
    localparam logic [31:0] V_B1 [NV] = '{32'h0000_0100, 32'hFFFF_FFF0, 32'h0055_0000, 32'h0000_0777};
    localparam int V_ST [NV] = '{0, 40, 10, 70};
    localparam int V_FP [NV] = '{0, 30, 60, 20};
    localparam bit V_RESTART [NV] = '{0, 0, 1, 0};

    logic clk, rst_n, start, done;
    logic [1:0] in_empty, in_rd, out_full, out_wr;
    logic [2*DW-1:0] in_data;
    logic [DW-1:0] out_data;

    int checks = 0, fails = 0;
    logic [31:0] src0 [16], src1 [16];
    logic [31:0] got0 [32], got1 [32], exp0 [32], exp1 [32];
    int p0, p1, n0, n1, e0, e1, ndone, viol_rd, viol_wr, st_pct, fp_pct, cyc, pop_cyc, wr_cyc;
    bit run_env;

    spw_ctrl #(.DW(DW), .I_CNT(I_CNT), .J_CNT(J_CNT), .N_PAR(N_PAR), .LAT(LAT)) u_spw_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .in_empty(in_empty), .in_data(in_data),
        .in_rd(in_rd), .out_full(out_full), .out_wr(out_wr), .out_data(out_data), .done(done)
    );

    initial begin
        clk = 0;
        forever #5 clk = ~clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // environment: drive at falling edge, observe 2 ns later
    initial begin
        in_empty = 2'b00; out_full = 2'b00; in_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (run_env) begin
                in_empty[0] = (p0 >= 16) || (($urandom % 100) < st_pct);
                in_empty[1] = (p1 >= 16) || (($urandom % 100) < st_pct);
                out_full[0] = ($urandom % 100) < fp_pct;
                out_full[1] = ($urandom % 100) < fp_pct;
                in_data = {src1[p1 % 16], src0[p0 % 16]};
            end else begin
                in_empty = 2'b00; out_full = 2'b00;
            end
            #2;
            if ((in_rd & in_empty) != 2'b00) viol_rd++;
            if ((out_wr & out_full) != 2'b00) viol_wr++;
            if (|in_rd && pop_cyc < 0) pop_cyc = cyc;
            if (|out_wr && wr_cyc < 0) wr_cyc = cyc;
            if (in_rd[0]) p0++;
            if (in_rd[1]) p1++;
            if (out_wr[0] && n0 < 32) begin got0[n0] = out_data; n0++; end
            if (out_wr[1] && n1 < 32) begin got1[n1] = out_data; n1++; end
            if (done) ndone++;
        end
    end

    // loop-nest model: R1 order, R2 read guards, R3 write guards, R6 function
    task automatic build_model();
        logic [31:0] op;
        int q0, q1;
        op = 32'd0; q0 = 0; q1 = 0; e0 = 0; e1 = 0;
        for (int i = 0; i < I_CNT; i++) begin
            for (int j = 0; j < J_CNT; j++) begin
                if (i < N_PAR) begin op = src0[q0]; q0++; end
                else if (i == N_PAR) begin op = src1[q1]; q1++; end
                if (i <= N_PAR - 1) begin exp0[e0] = (op << 1) + 32'd1; e0++; end
                if (j == J_CNT - 1) begin exp1[e1] = (op << 1) + 32'd1; e1++; end
            end
        end
    endtask

    task automatic run_sweep(input int v);
        int wd;
        for (int k = 0; k < 16; k++) begin
            src0[k] = V_B0[v] + 32'(k * 7);
            src1[k] = V_B1[v] + 32'(k * 13);
        end
        build_model();
        p0 = 0; p1 = 0; n0 = 0; n1 = 0; ndone = 0; viol_rd = 0; viol_wr = 0;
        pop_cyc = -1; wr_cyc = -1;
        st_pct = V_ST[v]; fp_pct = V_FP[v]; run_env = 1;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        wd = 0;
        while (ndone == 0 && wd < 5000) begin
            @(posedge clk);
            wd++;
            if (V_RESTART[v] && wd == 20) begin
                @(negedge clk); start = 1;   // R10: start while busy
                @(negedge clk); start = 0;
            end
        end
        check(wd < 5000, "R8", "watchdog before done", 32'(wd), 32'd5000);
        repeat (12) @(posedge clk);
        check(ndone == 1, "R8", "done pulses per sweep", 32'(ndone), 32'd1);
        check(n0 == e0, "R3", "port0 write count", 32'(n0), 32'(e0));
        check(n1 == e1, "R3", "port1 write count", 32'(n1), 32'(e1));
        check(p0 == N_PAR * J_CNT, "R2", "port0 pops", 32'(p0), 32'(N_PAR * J_CNT));
        check(p1 == J_CNT, "R2", "port1 pops", 32'(p1), 32'(J_CNT));
        check(viol_rd == 0, "R4", "pop while empty", 32'(viol_rd), 32'd0);
        check(viol_wr == 0, "R5", "push while full", 32'(viol_wr), 32'd0);
        for (int k = 0; k < e0 && k < n0; k++)
            check(got0[k] == exp0[k], "R7", "port0 token order/value", got0[k], exp0[k]);
        for (int k = 0; k < e1 && k < n1; k++)
            check(got1[k] == exp1[k], "R7", "port1 token order/value (R2 hold, R6)", got1[k], exp1[k]);
        if (V_ST[v] == 0 && V_FP[v] == 0)
            check(wr_cyc - pop_cyc == LAT + 2, "R6", "pop to first write cycles",
                  32'(wr_cyc - pop_cyc), 32'(LAT + 2));
        if (V_RESTART[v])
            check(ndone == 1 && n0 == e0, "R10", "start during sweep ignored", 32'(ndone), 32'd1);
        run_env = 0;
    endtask

    initial begin
        run_env = 0; start = 0; rst_n = 0; cyc = 0;
        p0 = 0; p1 = 0; n0 = 0; n1 = 0; ndone = 0; viol_rd = 0; viol_wr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R9: idle after reset, inputs hold data and outputs have space
        repeat (6) @(negedge clk);
        #3;
        check(in_rd == 2'b00, "R9", "no pop while idle", 32'(in_rd), 32'd0);
        check(out_wr == 2'b00, "R9", "no push while idle", 32'(out_wr), 32'd0);
        check(done == 1'b0, "R9", "done low after reset", 32'(done), 32'd0);
        check(p0 == 0 && ndone == 0, "R1", "nothing happens without start", 32'(p0), 32'd0);
        // vector table walk
        for (int v = 0; v < NV; v++) run_sweep(v);
        // directed: back-to-back sweep reuses the table entry with full stall mix
        run_sweep(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // global watchdog
    initial begin
        #1500000;
        fails++;
        checks++;
        $display("FAIL R8 global watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule